// File: doc/BRIEF.md
# Windowed Bayer Pixel Capture

This block receives a raster stream from an image sensor that marks each frame with a frame-valid envelope and each row with a row-valid envelope, carrying one 8-bit sample per clock while both envelopes are high. It derives 1-based row and column coordinates from those envelopes alone and forwards only the samples that lie inside a rectangle chosen by four bound inputs. The rectangle is sampled once per frame, when frame-valid rises. A typical setting keeps rows 1 to 480 and columns 9 to 648, which drops the eight leading dark columns and yields a 640 by 480 visible image.

Every forwarded sample carries a two-bit tag that names its colour filter. The tag comes from the parity of the sample's row and column in a mosaic whose odd rows hold green and blue and whose even rows hold red and green. The output stream also marks the first forwarded sample of a frame and the last forwarded sample of each row. A row that stops before the right-hand bound still gets its last forwarded sample marked.

Top module: `pix_window_rx`

## Requirements
- R1: While reset is held and on the first clock edges after its release, out_valid, out_sof and out_eol are low.
- R2: Coordinates start at 1. The column resets to 1 on each sample where row-valid rises and the row resets to 1 on the first row after frame-valid rises. The counters reach at least row 502 and column 667.
- R3: A sample is forwarded exactly when its row lies in [cfg_row_first, cfg_row_last] and its column in [cfg_col_first, cfg_col_last], both bounds inclusive. All other samples produce no output.
- R4: The four bound inputs are captured on the clock edge where frame-valid is first seen high. Changing them later in the frame has no effect until the next frame.
- R5: A frame whose captured first bound exceeds its last bound, on rows or on columns, produces no output at all.
- R6: out_color is 0 for green on an odd row, 1 for blue (odd row, even column), 2 for red (even row, odd column) and 3 for green on an even row. Odd columns of odd rows are green.
- R7: out_sof is high on the first forwarded sample of each frame and on no other sample.
- R8: out_eol is high on a forwarded sample whose column equals cfg_col_last, or that is the last sample of its row because row-valid falls right after it.
- R9: A sample presented before clock edge N appears with unchanged data on the outputs right after edge N+1. The latency is fixed at two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fv_in | input | 1 | Frame envelope from the sensor |
| rv_in | input | 1 | Row envelope from the sensor |
| data_in | input | DATA_W | Pixel sample |
| cfg_row_first | input | ROW_W | First row of the window (1-based) |
| cfg_row_last | input | ROW_W | Last row of the window |
| cfg_col_first | input | COL_W | First column of the window (1-based) |
| cfg_col_last | input | COL_W | Last column of the window |
| out_valid | output | 1 | Forwarded sample present |
| out_data | output | DATA_W | Forwarded sample |
| out_color | output | 2 | Colour filter tag |
| out_sof | output | 1 | First forwarded sample of the frame |
| out_eol | output | 1 | Last forwarded sample of the row |

## Verification
Every forwarded sample is due exactly two clock edges after the cycle in which the driver presents it. The first edge captures the sample with its coordinates, and the second registers the window decision together with the look-ahead for the row end. The driver records the cycle number at which each expected item falls due. The monitor samples on the falling edge and requires each output to match the head of the queue in that exact cycle. An output with no expected item, or an expected item whose cycle passes without an output, counts as a mismatch. Frames with changed bounds mid-frame, inverted bounds, short rows and counts up to 502 rows and 667 columns exercise the corner cases.

// File: rtl/pix_window_pkg.sv
package pix_window_pkg;

  // colour filter tag carried with each forwarded sample
  typedef enum logic [1:0] {
    CLR_GREEN_ODD  = 2'd0,
    CLR_BLUE       = 2'd1,
    CLR_RED        = 2'd2,
    CLR_GREEN_EVEN = 2'd3
  } pix_color_e;

endpackage

// File: rtl/pix_window_coord.sv
module pix_window_coord #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fv,
  input  logic             rv,
  output logic             frame_start,
  output logic             pix_ok,
  output logic [ROW_W-1:0] row_cur,
  output logic [COL_W-1:0] col_cur
);

  localparam logic [ROW_W-1:0] ROW_ONE = {{(ROW_W-1){1'b0}}, 1'b1};
  localparam logic [COL_W-1:0] COL_ONE = {{(COL_W-1){1'b0}}, 1'b1};
  localparam logic [ROW_W-1:0] ROW_MAX = '1;
  localparam logic [COL_W-1:0] COL_MAX = '1;

  logic             fv_q, rv_q;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             line_start, row_en, col_en;

  always_comb begin
    frame_start = fv & ~fv_q;
    pix_ok      = fv & rv;
    line_start  = pix_ok & ~rv_q;

    row_d = row_q;
    if (frame_start) begin
      row_d = rv ? ROW_ONE : '0;
    end else if (line_start && (row_q != ROW_MAX)) begin
      row_d = row_q + ROW_ONE;
    end

    col_d = col_q;
    if (line_start) begin
      col_d = COL_ONE;
    end else if (pix_ok && (col_q != COL_MAX)) begin
      col_d = col_q + COL_ONE;
    end

    row_en  = frame_start | line_start;
    col_en  = pix_ok;
    row_cur = row_d;
    col_cur = col_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q  <= 1'b0;
      rv_q  <= 1'b0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      fv_q <= fv;
      rv_q <= pix_ok;
      if (row_en) row_q <= row_d;
      if (col_en) col_q <= col_d;
    end
  end

endmodule

// File: rtl/pix_window_match.sv
module pix_window_match #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] cfg_row_first,
  input  logic [ROW_W-1:0] cfg_row_last,
  input  logic [COL_W-1:0] cfg_col_first,
  input  logic [COL_W-1:0] cfg_col_last,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             hit,
  output logic             col_end
);

  logic [ROW_W-1:0] r_lo_q, r_hi_q;
  logic [COL_W-1:0] c_lo_q, c_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_lo_q <= '0;
      r_hi_q <= '0;
      c_lo_q <= '0;
      c_hi_q <= '0;
    end else if (load) begin
      r_lo_q <= cfg_row_first;
      r_hi_q <= cfg_row_last;
      c_lo_q <= cfg_col_first;
      c_hi_q <= cfg_col_last;
    end
  end

  always_comb begin
    hit     = (row >= r_lo_q) && (row <= r_hi_q) &&
              (col >= c_lo_q) && (col <= c_hi_q);
    col_end = (col == c_hi_q);
  end

endmodule

// File: rtl/pix_window_color.sv
module pix_window_color
  import pix_window_pkg::*;
(
  input  logic       row_odd,
  input  logic       col_odd,
  output pix_color_e color
);

  always_comb begin
    if (row_odd) color = col_odd ? CLR_GREEN_ODD : CLR_BLUE;
    else         color = col_odd ? CLR_RED       : CLR_GREEN_EVEN;
  end

endmodule

// File: rtl/pix_window_rx.sv
module pix_window_rx
  import pix_window_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fv_in,
  input  logic              rv_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [ROW_W-1:0]  cfg_row_first,
  input  logic [ROW_W-1:0]  cfg_row_last,
  input  logic [COL_W-1:0]  cfg_col_first,
  input  logic [COL_W-1:0]  cfg_col_last,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_color,
  output logic              out_sof,
  output logic              out_eol
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // coordinate tracking on the raw input
  logic             frame_start, pix_ok;
  logic [ROW_W-1:0] row_cur;
  logic [COL_W-1:0] col_cur;

  pix_window_coord #(.ROW_W(ROW_W), .COL_W(COL_W)) u_coord (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .fv          (fv_in),
    .rv          (rv_in),
    .frame_start (frame_start),
    .pix_ok      (pix_ok),
    .row_cur     (row_cur),
    .col_cur     (col_cur)
  );

  // capture stage
  logic              s1_vld_q;
  logic [DATA_W-1:0] s1_data_q;
  logic [ROW_W-1:0]  s1_row_q;
  logic [COL_W-1:0]  s1_col_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_vld_q  <= 1'b0;
      s1_data_q <= '0;
      s1_row_q  <= '0;
      s1_col_q  <= '0;
    end else begin
      s1_vld_q <= pix_ok;
      if (pix_ok) begin
        s1_data_q <= data_in;
        s1_row_q  <= row_cur;
        s1_col_q  <= col_cur;
      end
    end
  end

  // window decision with latched bounds
  logic hit, col_end;

  pix_window_match #(.ROW_W(ROW_W), .COL_W(COL_W)) u_match (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .load          (frame_start),
    .cfg_row_first (cfg_row_first),
    .cfg_row_last  (cfg_row_last),
    .cfg_col_first (cfg_col_first),
    .cfg_col_last  (cfg_col_last),
    .row           (s1_row_q),
    .col           (s1_col_q),
    .hit           (hit),
    .col_end       (col_end)
  );

  pix_color_e s1_color;

  pix_window_color u_color (
    .row_odd (s1_row_q[0]),
    .col_odd (s1_col_q[0]),
    .color   (s1_color)
  );

  // output stage: next-state
  logic emit, sof_pend_q, sof_pend_d;
  logic vld_d, sof_d, eol_d;

  always_comb begin
    emit  = s1_vld_q & hit;
    vld_d = emit;
    sof_d = emit & sof_pend_q;
    // pixel ends its row if it hits the right bound or no sample follows it
    eol_d = emit & (col_end | ~pix_ok);

    sof_pend_d = sof_pend_q;
    if (frame_start) sof_pend_d = 1'b1;
    else if (emit)   sof_pend_d = 1'b0;
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sof_pend_q <= 1'b0;
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      out_eol    <= 1'b0;
      out_data   <= '0;
      out_color  <= 2'd0;
    end else begin
      sof_pend_q <= sof_pend_d;
      out_valid  <= vld_d;
      out_sof    <= sof_d;
      out_eol    <= eol_d;
      if (emit) begin
        out_data  <= s1_data_q;
        out_color <= s1_color;
      end
    end
  end

endmodule

// File: rtl/pix_window_rx_chk.sv
module pix_window_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fv_in,
  input logic       rv_in,
  input logic       out_valid,
  input logic [1:0] out_color,
  input logic       out_sof,
  input logic       out_eol
);

  logic fv_q, sof_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q       <= 1'b0;
      sof_seen_q <= 1'b0;
    end else begin
      fv_q <= fv_in;
      if (fv_in && !fv_q) sof_seen_q <= 1'b0;
      else if (out_sof)   sof_seen_q <= 1'b1;
    end
  end

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R7

  AST_EOL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid); // R8

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(fv_in && rv_in, 2)); // R9

  AST_COLOR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && !$past(out_eol)) |->
      ((out_color[0] != $past(out_color[0])) && (out_color[1] == $past(out_color[1])))); // R6

  AST_SINGLE_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !sof_seen_q); // R7

endmodule

bind pix_window_rx pix_window_rx_chk u_pix_window_rx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fv_in     (fv_in),
  .rv_in     (rv_in),
  .out_valid (out_valid),
  .out_color (out_color),
  .out_sof   (out_sof),
  .out_eol   (out_eol)
);

// File: tb/pix_window_rx_bench.sv
`timescale 1ns/1ps
module pix_window_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fv_in, rv_in;
  logic [7:0] data_in;
  logic [9:0] cfg_row_first, cfg_row_last, cfg_col_first, cfg_col_last;
  logic       out_valid, out_sof, out_eol;
  logic [7:0] out_data;
  logic [1:0] out_color;

  always #4 clk = ~clk;

  pix_window_rx u_pix_window_rx (
    .clk(clk), .rst_n(rst_n), .fv_in(fv_in), .rv_in(rv_in), .data_in(data_in),
    .cfg_row_first(cfg_row_first), .cfg_row_last(cfg_row_last),
    .cfg_col_first(cfg_col_first), .cfg_col_last(cfg_col_last),
    .out_valid(out_valid), .out_data(out_data), .out_color(out_color),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  typedef struct {
    int       cyc;
    int       d;
    int       clr;
    int       sof;
    int       eol;
    string    tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected output", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, "R9", "due cycle", cyc, e.cyc);
          chk(int'(out_data) == e.d, "R9", "data", int'(out_data), e.d);
          chk(int'(out_color) == e.clr, "R6", "color", int'(out_color), e.clr);
          chk(int'(out_sof) == e.sof, "R7", "sof", int'(out_sof), e.sof);
          chk(int'(out_eol) == e.eol, "R8", "eol", int'(out_eol), e.eol);
        end
      end else if (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(1'b0, e.tag, "missing output", 0, 1);
      end
    end
  end

  function automatic int color_of(input int r, input int c);
    if (r % 2 == 1) return (c % 2 == 1) ? 0 : 1;
    return (c % 2 == 1) ? 2 : 3;
  endfunction

  task automatic run_frame(input int nrows, input int base_len,
                           input int short_row, input int short_len,
                           input int rlo, input int rhi, input int clo, input int chi,
                           input bit scramble, input int seed, input string tag);
    bit first = 1'b1;
    cur_tag = tag;
    @(negedge clk);
    cfg_row_first = 10'(rlo); cfg_row_last = 10'(rhi);
    cfg_col_first = 10'(clo); cfg_col_last = 10'(chi);
    fv_in = 1'b1;
    repeat (2) @(negedge clk);
    for (int r = 1; r <= nrows; r++) begin
      int len = (r == short_row) ? short_len : base_len;
      for (int c = 1; c <= len; c++) begin
        bit inwin;
        if (c > 1 || r > 1 || 1) begin end
        if (!(r == 1 && c == 1)) @(negedge clk);
        rv_in   = 1'b1;
        data_in = 8'((r * 7 + c * 3 + seed) & 255);
        inwin = (r >= rlo) && (r <= rhi) && (c >= clo) && (c <= chi);
        if (inwin) begin
          exp_t e;
          e.cyc = cyc + 2;
          e.d   = (r * 7 + c * 3 + seed) & 255;
          e.clr = color_of(r, c);
          e.sof = first ? 1 : 0;
          e.eol = ((c == chi) || (c == len)) ? 1 : 0;
          e.tag = tag;
          first = 1'b0;
          q.push_back(e);
        end
      end
      @(negedge clk);
      rv_in = 1'b0;
      if (scramble && r == 1) begin
        cfg_row_first = 10'd1; cfg_row_last = 10'd1000;
        cfg_col_first = 10'd1; cfg_col_last = 10'd1000;
      end
      repeat (3) @(negedge clk);
    end
    fv_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(q.size() == 0, tag, "items left after frame", q.size(), 0);
    q.delete();
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fv_in = 1'b0; rv_in = 1'b0; data_in = '0;
    cfg_row_first = 10'd1; cfg_row_last = 10'd480;
    cfg_col_first = 10'd9; cfg_col_last = 10'd648;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    chk(out_sof == 1'b0, "R1", "sof in reset", int'(out_sof), 0);
    chk(out_eol == 1'b0, "R1", "eol in reset", int'(out_eol), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after release", int'(out_valid), 0);

    // R3: interior window
    run_frame(6, 10, 0, 0, 2, 4, 3, 6, 1'b0, 11, "R3");
    // R3: whole frame forwarded, window larger than frame
    run_frame(3, 5, 0, 0, 1, 20, 1, 20, 1'b0, 40, "R3");
    // R8: short row stops inside the window
    run_frame(4, 12, 2, 5, 1, 4, 3, 9, 1'b0, 3, "R8");
    // R8: short row stops before the window begins
    run_frame(3, 8, 2, 2, 1, 3, 4, 6, 1'b0, 5, "R8");
    // R4: bounds changed after first row have no effect
    run_frame(5, 8, 0, 0, 2, 3, 2, 5, 1'b1, 77, "R4");
    // R5: inverted rows, then inverted columns
    run_frame(4, 8, 0, 0, 3, 2, 1, 8, 1'b0, 9, "R5");
    run_frame(4, 8, 0, 0, 1, 4, 6, 2, 1'b0, 9, "R5");
    // R2: high row count and wide rows
    run_frame(502, 2, 0, 0, 500, 502, 1, 2, 1'b0, 21, "R2");
    run_frame(2, 667, 0, 0, 1, 2, 664, 667, 1'b0, 60, "R2");
    // R2 + R6: skip leading dark columns with typical window
    run_frame(3, 20, 0, 0, 1, 480, 9, 648, 1'b0, 99, "R2");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule